// File: doc/BRIEF.md
# Option-Configured Reset Boot Sequencer

This block brings a small controller out of power-on reset. It keeps the system in reset while the supply comparator reports low power. It also waits while the low-voltage detector says the regulated rails are not yet safe. Once both flags are good, it runs a fixed two-step exit. The first step turns on the clock generator while internal reset and the reset-pin drive stay asserted. The second step also opens the core, system, flash and default-on bus clocks. Only after that second step does it release internal reset and stop driving the reset pin low. Each step lasts a parameter-set number of cycles.

An eight-bit option byte is captured once, right after power-on reset. From then on the captured copy decides three things. It decides whether the external reset pin works as a filtered reset input with pull-up. It decides whether the non-maskable interrupt may be raised or may wake the part. It decides the reset value given to the core clock divider field. Later system resets do not capture the byte again: a pin-triggered restart or a brown-out drop of the safe flag leaves the captured copy as it is. All pins are plain level signals; there is no data stream and so no handshake.

Top module: `boot_seq_top`

## Requirements
- R1: While `por_ok` is low, `sys_rst_n` is 0, `pin_drive_low` is 1, and `clkgen_en`, `core_clk_en`, every `bus_clk_en` bit and `nmi_req` are 0.
- R2: With `por_ok` high and `lvd_safe` low, the block stays in the hold state: `clkgen_en` is 0 and `sys_rst_n` is 0, however long this lasts.
- R3: After `lvd_safe` rises, `clkgen_en` is 1 for exactly STEP_CYC cycles before any clock enable opens. During those cycles `sys_rst_n` is 0 and `pin_drive_low` is 1.
- R4: Next, `core_clk_en`, `sys_clk_en` and `flash_clk_en` are 1 and `bus_clk_en` equals BUS_ON_MASK for exactly STEP_CYC cycles with reset still held. Then `sys_rst_n` goes to 1 and `pin_drive_low` goes to 0 in the same cycle.
- R5: Captured option bit 3 = 1 sets `pin_reset_en`, `pin_pullup_en`, `pin_filter_en` and `rst_wake_en` to 1. Bit 3 = 0 sets all four to 0.
- R6: Captured option bit 2 sets `nmi_en` and `nmi_wake_en`. `nmi_req` is 1 only when `nmi_en` is 1, the block is out of reset, and `nmi_n` has been low for 2 synchronizer cycles. It is 0 in every other case.
- R7: `div_rst_val` is 1 (divide by 2) when captured option bit 0 is 0. It is 0 (divide by 1) when that bit is 1.
- R8: Option bits 7, 6, 5, 4 and 1 change no output.
- R9: The option byte is sampled once after each rise of `por_ok`. Changes on `opt_byte` after that have no effect, including across pin-triggered restarts and `lvd_safe` drops, until the next power-on reset.
- R10: With `pin_reset_en` = 1 and the block running, `rst_pin_n` low for 2 or more synchronized cycles restarts the exit sequence at the clock-generator step. `sys_rst_n` falls 5 cycles after the pin is driven low. A 1-cycle low pulse does nothing. With `pin_reset_en` = 0 the pin does nothing.
- R11: A low on `lvd_safe` returns the block to the hold state, with `clkgen_en` = 0 three cycles later. When the flag returns, the full two-step sequence runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_ok | input | 1 | Supply above power-on threshold; low is power-on reset (asynchronous assert) |
| lvd_safe | input | 1 | Regulated supplies safe (asynchronous, synchronized inside) |
| rst_pin_n | input | 1 | External reset pin level, active low (asynchronous) |
| nmi_n | input | 1 | NMI pin level, active low (asynchronous) |
| opt_byte | input | 8 | Factory option byte, stable around power-on |
| sys_rst_n | output | 1 | Internal system reset, active low |
| pin_drive_low | output | 1 | Drive the reset pin low |
| clkgen_en | output | 1 | Clock generator enable (default mode) |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| bus_clk_en | output | BUS_N | Bus clock enables, default-on set given by BUS_ON_MASK |
| pin_reset_en | output | 1 | Reset pin acts as reset input |
| pin_pullup_en | output | 1 | Reset pin pull-up enable |
| pin_filter_en | output | 1 | Reset pin passive filter enable |
| rst_wake_en | output | 1 | Reset pin allowed as wake-up source |
| nmi_en | output | 1 | NMI not blocked |
| nmi_wake_en | output | 1 | NMI allowed as wake-up source |
| nmi_req | output | 1 | Gated NMI request |
| div_rst_val | output | DIV_W | Reset value for the core/system divider field |

## Verification
The checker watches every cycle for the ordering rules. The clock generator is on whenever the clocks are. Reset is released only from the clock step. The pin is driven whenever reset is held. The bus enables match their mask. The NMI request stays off when NMI is blocked or the system is in reset. The divider value never leaves {0,1}. The configuration never moves while the system runs. A sustained safe-flag loss always reaches hold, and a disabled pin never drops a running system. Only the bench can show the exact step lengths and the 5-cycle pin latency. The bench also shows that a 1-cycle pin glitch is filtered, that the option capture outlives system resets while live byte changes are ignored, and the full mapping of all 256 option values.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_GEN  = 2'd1,
    ST_CLK  = 2'd2,
    ST_RUN  = 2'd3
  } boot_st_e;

  localparam int OPT_W       = 8;
  localparam int OPT_PIN_BIT = 3;
  localparam int OPT_NMI_BIT = 2;
  localparam int OPT_DIV_BIT = 0;

  typedef struct packed {
    logic pin_en;
    logic nmi_en;
    logic div_full;
  } opt_cfg_t;
endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/boot_opt_latch.sv
module boot_opt_latch
  import boot_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPT_W-1:0] opt_byte,
  output opt_cfg_t         cfg,
  output logic             cap_done
);
  localparam logic [OPT_W-1:0] SEL_PIN = OPT_W'(1) << OPT_PIN_BIT;
  localparam logic [OPT_W-1:0] SEL_NMI = OPT_W'(1) << OPT_NMI_BIT;
  localparam logic [OPT_W-1:0] SEL_DIV = OPT_W'(1) << OPT_DIV_BIT;

  opt_cfg_t decoded;

  always_comb begin
    decoded.pin_en   = |(opt_byte & SEL_PIN);
    decoded.nmi_en   = |(opt_byte & SEL_NMI);
    decoded.div_full = |(opt_byte & SEL_DIV);
  end

  // One capture per power-on reset; system restarts never reach here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      cap_done <= 1'b0;
    end else if (!cap_done) begin
      cfg      <= decoded;
      cap_done <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_pin_filter.sv
module boot_pin_filter #(
  parameter int LOW_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin_s,
  output logic evt
);
  localparam int CW = $clog2(LOW_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(LOW_CYC);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!arm || pin_s) begin
      low_cnt <= '0;
    end else if (low_cnt != LIM) begin
      low_cnt <= low_cnt + CW'(1);
    end
  end

  assign evt = arm && (low_cnt == LIM);
endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import boot_seq_pkg::*;
#(
  parameter int STEP_CYC = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     lvd_ok,
  input  logic     cap_done,
  input  logic     pin_evt,
  output boot_st_e state
);
  localparam int CW = $clog2(STEP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

  boot_st_e      nxt;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (cnt == LAST);

  always_comb begin
    nxt = state;
    if (!lvd_ok) begin
      nxt = ST_HOLD;
    end else begin
      case (state)
        ST_HOLD: if (cap_done) nxt = ST_GEN;
        ST_GEN:  if (last)     nxt = ST_CLK;
        ST_CLK:  if (last)     nxt = ST_RUN;
        ST_RUN:  if (pin_evt)  nxt = ST_GEN;
        default:               nxt = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) begin
        cnt <= '0;
      end else if (!last) begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int          STEP_CYC    = 16,
  parameter int          BUS_N       = 4,
  parameter int unsigned BUS_ON_MASK = 32'h3,
  parameter int          DIV_W       = 4,
  parameter int          PIN_LOW_CYC = 2
) (
  input  logic             clk,
  input  logic             por_ok,
  input  logic             lvd_safe,
  input  logic             rst_pin_n,
  input  logic             nmi_n,
  input  logic [OPT_W-1:0] opt_byte,
  output logic             sys_rst_n,
  output logic             pin_drive_low,
  output logic             clkgen_en,
  output logic             core_clk_en,
  output logic             sys_clk_en,
  output logic             flash_clk_en,
  output logic [BUS_N-1:0] bus_clk_en,
  output logic             pin_reset_en,
  output logic             pin_pullup_en,
  output logic             pin_filter_en,
  output logic             rst_wake_en,
  output logic             nmi_en,
  output logic             nmi_wake_en,
  output logic             nmi_req,
  output logic [DIV_W-1:0] div_rst_val
);
  logic [1:0] por_sr;
  logic       core_rst_n;
  logic [2:0] raw_in;
  logic [2:0] sync_in;
  logic       pin_s;
  logic       nmi_s;
  logic       lvd_s;
  opt_cfg_t   cfg;
  logic       cap_done;
  logic       pin_evt;
  boot_st_e   state;
  logic       clk_on;
  logic       running;

  // Power-on reset: asynchronous entry, synchronized exit.
  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) por_sr <= 2'b00;
    else         por_sr <= {por_sr[0], 1'b1};
  end
  assign core_rst_n = por_sr[1];

  assign raw_in = {rst_pin_n, nmi_n, lvd_safe};

  boot_sync #(.W(3), .RST_VAL(3'b110)) i_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );
  assign pin_s = sync_in[2];
  assign nmi_s = sync_in[1];
  assign lvd_s = sync_in[0];

  boot_opt_latch i_opt (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .opt_byte (opt_byte),
    .cfg      (cfg),
    .cap_done (cap_done)
  );

  boot_pin_filter #(.LOW_CYC(PIN_LOW_CYC)) i_pin (
    .clk   (clk),
    .rst_n (core_rst_n),
    .arm   (running && cfg.pin_en),
    .pin_s (pin_s),
    .evt   (pin_evt)
  );

  boot_fsm #(.STEP_CYC(STEP_CYC)) i_fsm (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .lvd_ok   (lvd_s),
    .cap_done (cap_done),
    .pin_evt  (pin_evt),
    .state    (state)
  );

  assign running       = (state == ST_RUN);
  assign clk_on        = (state == ST_CLK) || running;
  assign sys_rst_n     = running;
  assign pin_drive_low = !running;
  assign clkgen_en     = (state != ST_HOLD);
  assign core_clk_en   = clk_on;
  assign sys_clk_en    = clk_on;
  assign flash_clk_en  = clk_on;

  for (genvar g = 0; g < BUS_N; g++) begin : g_bus
    if (BUS_ON_MASK[g]) begin : g_on
      assign bus_clk_en[g] = clk_on;
    end else begin : g_off
      assign bus_clk_en[g] = 1'b0;
    end
  end

  assign pin_reset_en  = cfg.pin_en;
  assign pin_pullup_en = cfg.pin_en;
  assign pin_filter_en = cfg.pin_en;
  assign rst_wake_en   = cfg.pin_en;
  assign nmi_en        = cfg.nmi_en;
  assign nmi_wake_en   = cfg.nmi_en;
  assign nmi_req       = cfg.nmi_en && running && !nmi_s;
  assign div_rst_val   = cfg.div_full ? '0 : DIV_W'(1);
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int          BUS_N       = 4,
  parameter int unsigned BUS_ON_MASK = 32'h3,
  parameter int          DIV_W       = 4
) (
  input logic             clk,
  input logic             por_ok,
  input logic             lvd_safe,
  input logic             sys_rst_n,
  input logic             pin_drive_low,
  input logic             clkgen_en,
  input logic             core_clk_en,
  input logic             sys_clk_en,
  input logic             flash_clk_en,
  input logic [BUS_N-1:0] bus_clk_en,
  input logic             pin_reset_en,
  input logic             nmi_en,
  input logic             nmi_req,
  input logic [DIV_W-1:0] div_rst_val
);
  p_gen_before_clk_r3: assert property (@(posedge clk) disable iff (!por_ok)
    core_clk_en |-> clkgen_en);

  p_release_from_clk_r4: assert property (@(posedge clk) disable iff (!por_ok)
    $rose(sys_rst_n) |-> $past(core_clk_en));

  p_pin_held_r4: assert property (@(posedge clk) disable iff (!por_ok)
    !sys_rst_n |-> pin_drive_low);

  p_clk_set_r4: assert property (@(posedge clk) disable iff (!por_ok)
    core_clk_en |-> (sys_clk_en && flash_clk_en && bus_clk_en == BUS_N'(BUS_ON_MASK)));

  p_bus_off_r4: assert property (@(posedge clk) disable iff (!por_ok)
    !core_clk_en |-> (bus_clk_en == '0));

  p_nmi_gate_r6: assert property (@(posedge clk) disable iff (!por_ok)
    (!nmi_en || !sys_rst_n) |-> !nmi_req);

  p_div_range_r7: assert property (@(posedge clk) disable iff (!por_ok)
    div_rst_val <= DIV_W'(1));

  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!por_ok)
    sys_rst_n |-> $stable({pin_reset_en, nmi_en, div_rst_val}));

  p_pin_off_r10: assert property (@(posedge clk) disable iff (!por_ok)
    (sys_rst_n && $past(sys_rst_n) && !pin_reset_en &&
     lvd_safe && $past(lvd_safe) && $past(lvd_safe, 2)) |=> sys_rst_n);

  p_lvd_hold_r11: assert property (@(posedge clk) disable iff (!por_ok)
    (!lvd_safe && !$past(lvd_safe) && !$past(lvd_safe, 2)) |=> !clkgen_en);
endmodule

bind boot_seq_top boot_seq_chk #(
  .BUS_N       (BUS_N),
  .BUS_ON_MASK (BUS_ON_MASK),
  .DIV_W       (DIV_W)
) i_boot_seq_chk (
  .clk           (clk),
  .por_ok        (por_ok),
  .lvd_safe      (lvd_safe),
  .sys_rst_n     (sys_rst_n),
  .pin_drive_low (pin_drive_low),
  .clkgen_en     (clkgen_en),
  .core_clk_en   (core_clk_en),
  .sys_clk_en    (sys_clk_en),
  .flash_clk_en  (flash_clk_en),
  .bus_clk_en    (bus_clk_en),
  .pin_reset_en  (pin_reset_en),
  .nmi_en        (nmi_en),
  .nmi_req       (nmi_req),
  .div_rst_val   (div_rst_val)
);

// File: tb/test_boot_seq_top.sv
module test_boot_seq_top;
  localparam int          STEP   = 5;
  localparam int          BUSN   = 3;
  localparam int unsigned BMASK  = 32'h5;
  localparam int          DIVW   = 4;

  logic            clk = 1'b0;
  logic            por_ok = 1'b1;
  logic            lvd_safe = 1'b0;
  logic            rst_pin_n = 1'b1;
  logic            nmi_n = 1'b1;
  logic [7:0]      opt_byte = 8'h00;
  logic            sys_rst_n, pin_drive_low, clkgen_en, core_clk_en;
  logic            sys_clk_en, flash_clk_en;
  logic [BUSN-1:0] bus_clk_en;
  logic            pin_reset_en, pin_pullup_en, pin_filter_en, rst_wake_en;
  logic            nmi_en, nmi_wake_en, nmi_req;
  logic [DIVW-1:0] div_rst_val;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  boot_seq_top #(
    .STEP_CYC(STEP), .BUS_N(BUSN), .BUS_ON_MASK(BMASK), .DIV_W(DIVW)
  ) i_boot_seq_top (
    .clk(clk), .por_ok(por_ok), .lvd_safe(lvd_safe), .rst_pin_n(rst_pin_n),
    .nmi_n(nmi_n), .opt_byte(opt_byte), .sys_rst_n(sys_rst_n),
    .pin_drive_low(pin_drive_low), .clkgen_en(clkgen_en),
    .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .flash_clk_en(flash_clk_en), .bus_clk_en(bus_clk_en),
    .pin_reset_en(pin_reset_en), .pin_pullup_en(pin_pullup_en),
    .pin_filter_en(pin_filter_en), .rst_wake_en(rst_wake_en),
    .nmi_en(nmi_en), .nmi_wake_en(nmi_wake_en), .nmi_req(nmi_req),
    .div_rst_val(div_rst_val)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Power-on reset with a given option byte; lvd_safe left low.
  task automatic do_por(input logic [7:0] v, input bit check_r1);
    @(negedge clk);
    por_ok   = 1'b0;
    lvd_safe = 1'b0;
    opt_byte = v;
    repeat (3) @(negedge clk);
    if (check_r1) begin
      chk_eq("R1 sys_rst_n", sys_rst_n, 0);
      chk_eq("R1 pin_drive_low", pin_drive_low, 1);
      chk_eq("R1 clkgen_en", clkgen_en, 0);
      chk_eq("R1 core_clk_en", core_clk_en, 0);
      chk_eq("R1 bus_clk_en", bus_clk_en, 0);
      chk_eq("R1 nmi_req", nmi_req, 0);
    end
    por_ok = 1'b1;
  endtask

  // Count the two exit steps from the present sample until release.
  task automatic run_seq(input string tag);
    int c1 = 0;
    int c2 = 0;
    int nodrv = 0;
    int guard = 0;
    while (!sys_rst_n && guard < 400) begin
      if (clkgen_en && !core_clk_en) c1++;
      if (core_clk_en && !sys_rst_n) c2++;
      if (!pin_drive_low) nodrv++;
      guard++;
      @(negedge clk);
    end
    chk_eq({tag, " R3 generator step length"}, c1, STEP);
    chk_eq({tag, " R4 clock step length"}, c2, STEP);
    chk_eq({tag, " R3 pin drive during reset"}, nodrv, 0);
    chk_eq({tag, " R4 released pin drive"}, pin_drive_low, 0);
    chk_eq({tag, " R4 bus enables"}, bus_clk_en, BMASK);
  endtask

  task automatic boot(input logic [7:0] v, input string tag);
    do_por(v, 1'b0);
    repeat (2) @(negedge clk);
    lvd_safe = 1'b1;
    run_seq(tag);
  endtask

  task automatic chk_cfg(input logic [7:0] v, input string tag);
    int ep = int'(v[3]);
    int en = int'(v[2]);
    int ed = v[0] ? 0 : 1;
    chk_eq({tag, " R5 pin_reset_en"}, pin_reset_en, ep);
    chk_eq({tag, " R5 pullup/filter/wake"},
           {pin_pullup_en, pin_filter_en, rst_wake_en}, ep * 7);
    chk_eq({tag, " R6 nmi_en/wake"}, {nmi_en, nmi_wake_en}, en * 3);
    chk_eq({tag, " R7 div_rst_val"}, div_rst_val, ed);
  endtask

  // Drive pin low for len cycles; return cycles until sys_rst_n fell (0 = none).
  task automatic pin_pulse(input int len, output int fall_at);
    fall_at = 0;
    @(negedge clk);
    rst_pin_n = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (i == len) rst_pin_n = 1'b1;
      if (!sys_rst_n && fall_at == 0) fall_at = i;
    end
    rst_pin_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int fa;
    int ref_cfg;
    #5 por_ok = 1'b0;

    // R1 and R2: hold while power is not good.
    do_por(8'h0D, 1'b1);
    repeat (40) @(negedge clk);
    chk_eq("R2 clkgen_en in hold", clkgen_en, 0);
    chk_eq("R2 sys_rst_n in hold", sys_rst_n, 0);
    lvd_safe = 1'b1;
    run_seq("first");

    // R5 R6 R7 R8: every option byte value.
    for (int v = 0; v < 256; v++) begin
      boot(8'(v), "sweep");
      chk_cfg(8'(v), "sweep");
      ref_cfg = int'(v[3]) * 4 + int'(v[2]) * 2 + (v[0] ? 0 : 1);
      chk_eq("R8 reserved bits ignored",
             {pin_reset_en, nmi_en, div_rst_val[0]}, ref_cfg);
    end

    // R9: captured copy survives live changes and system restarts.
    boot(8'h0D, "persist");
    opt_byte = 8'h00;
    repeat (6) @(negedge clk);
    chk_cfg(8'h0D, "R9 live change");
    pin_pulse(4, fa);
    chk_eq("R10 pin restart latency", fa, 5);
    chk_cfg(8'h0D, "R9 after pin restart");
    while (!sys_rst_n) @(negedge clk);
    chk_cfg(8'h0D, "R9 after pin restart run");

    // R11: supply-safe drop returns to hold, then full sequence.
    @(negedge clk);
    lvd_safe = 1'b0;
    fa = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (!clkgen_en && fa == 0) fa = i;
    end
    chk_eq("R11 hold latency", fa, 3);
    lvd_safe = 1'b1;
    run_seq("R11 recover");
    chk_cfg(8'h0D, "R9 after lvd restart");

    // R10: glitch, minimum pulse, restart from generator step.
    pin_pulse(1, fa);
    chk_eq("R10 one-cycle glitch ignored", fa, 0);
    chk_eq("R10 still running", sys_rst_n, 1);
    @(negedge clk);
    rst_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_pin_n = 1'b1;
    fa = 0;
    while (sys_rst_n && fa < 10) begin
      @(negedge clk);
      fa++;
    end
    chk_eq("R10 two-cycle pulse restarts", sys_rst_n, 0);
    chk_eq("R10 restart keeps generator", clkgen_en, 1);
    chk_eq("R10 restart closes clocks", core_clk_en, 0);
    run_seq("R10 restart");

    // R6: NMI request gating and latency.
    boot(8'h04, "nmi");
    @(negedge clk);
    nmi_n = 1'b0;
    @(negedge clk);
    chk_eq("R6 nmi_req after 1 cycle", nmi_req, 0);
    @(negedge clk);
    chk_eq("R6 nmi_req after 2 cycles", nmi_req, 1);
    nmi_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R6 nmi_req released", nmi_req, 0);
    nmi_n = 1'b0;
    do_por(8'h04, 1'b0);
    repeat (8) @(negedge clk);
    chk_eq("R6 nmi_req blocked in reset", nmi_req, 0);
    nmi_n = 1'b1;

    // R9 re-evaluation at next power-on, R10 disabled pin, R6 blocked NMI.
    boot(8'h00, "disabled");
    chk_cfg(8'h00, "R9 new capture");
    pin_pulse(6, fa);
    chk_eq("R10 disabled pin ignored", fa, 0);
    nmi_n = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R6 blocked nmi_req", nmi_req, 0);
    nmi_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule